// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block models a two-bank synchronous burst SRAM with a 72-bit word made of eight 9-bit byte lanes. On every rising clock edge it captures the address, two active-low bank enables, an active-low global write, an active-low byte-write-mode gate, eight active-low per-lane write enables and the write data. Reads are flow-through: the word at the registered address shows on the output in the cycle after the edge, with no output register, so a burst delivers its first beat two cycles after the address is presented and each later beat one cycle later (2-1-1-1).

An access starts when either address strobe is low. The controller strobe allows writes; the processor strobe starts a read only. With both strobes high, a low advance input steps a four-beat sequential burst. The two low address bits count modulo 4 inside the aligned block. With the controller strobe tied low and the processor strobe and advance tied high, every cycle loads a fresh address and writes complete in the same edge (synchronous-only operation). The data bus is given as an output word plus a pad enable. The output enable reaches that pad enable through logic only, with no register in the path.

Top module: `sync_burst_sram`

## Requirements
- R1: While reset is high at a clock edge, the pad enable `dq_oe` is low after that edge. Reset clears the access state to deselected.
- R2: When an access loads address A in bank B and `oe_n` is low, `dq_out` carries word A of bank B in the cycle after the loading edge, and `dq_oe` is high.
- R3: With `gw_n` low on a selected, write-permitted edge, all eight lanes of the accessed word take `dq_in`, whatever `bwe_n` and `bw_n` are.
- R4: With `gw_n` high and `bwe_n` low, lane i (bits 9i+8 down to 9i) is written only when `bw_n[i]` is low; the other lanes keep their old contents.
- R5: With `gw_n` and `bwe_n` both high, no lane is written, whatever `bw_n` is.
- R6: On an edge where both strobes are high and `adv_n` is low, the access address bits [1:0] step by one modulo 4 and the upper bits stay unchanged. With `adv_n` high as well, the address holds.
- R7: Whenever `oe_n` is high, `dq_oe` is low at once, with no clock edge needed. Lowering `oe_n` during a readable cycle raises `dq_oe` at once.
- R8: An access loaded with both `en1_n` and `en2_n` high is deselected. It writes nothing, and `dq_oe` stays low until the next selected load.
- R9: `en1_n` low selects bank 0. `en2_n` low alone selects bank 1. Both low selects bank 0. The two banks hold independent contents at the same address.
- R10: A load by the processor strobe (`adsp_n` low) is a read and writes nothing, even if write controls are active. It has priority over the controller strobe.
- R11: In a cycle that follows a write edge, `dq_oe` is low. A read of the same word on the next access returns the new data.
- R12: The bank selection is captured only on load edges and holds through advance and hold cycles, whatever the bank enables do then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Word address within a bank |
| adsc_n | input | 1 | Controller address strobe, active low, allows writes |
| adsp_n | input | 1 | Processor address strobe, active low, read only, has priority |
| adv_n | input | 1 | Burst advance, active low |
| en1_n | input | 1 | Bank 0 enable, active low |
| en2_n | input | 1 | Bank 1 enable, active low |
| gw_n | input | 1 | Global write, all lanes, active low |
| bwe_n | input | 1 | Byte-write-mode gate, active low |
| bw_n | input | 8 | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable, asynchronous, active low |
| dq_in | input | 72 | Write data captured at the edge |
| dq_out | output | 72 | Flow-through read data |
| dq_oe | output | 1 | Pad drive enable for the data bus |

## Verification
A burst advance and a lane-masked write can fall on the same edge. The write then lands on the freshly incremented, wrapped address rather than on the previous one. The random phase holds both strobes high with `adv_n` low while the write controls are active, and it starts bursts near the top of an aligned block. A reference array in the bench applies the write at the stepped address and then compares each later read beat. In the same way, a processor-strobe load that coincides with active global write is judged by reading the word back unchanged.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int LANES  = 8;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;
  localparam int BANKS  = 2;

  // one-hot bank select, all-zero means deselected
  typedef logic [BANKS-1:0] bank_t;

  function automatic bank_t pick_bank(input logic e1_n, input logic e2_n);
    bank_t b;
    b = '0;
    if (!e1_n)      b[0] = 1'b1;
    else if (!e2_n) b[1] = 1'b1;
    return b;
  endfunction
endpackage

// File: rtl/burst_addr_ctrl.sv
module burst_addr_ctrl
  import sram_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          adsc_n,
  input  logic          adsp_n,
  input  logic          adv_n,
  input  logic          en1_n,
  input  logic          en2_n,
  output logic [AW-1:0] nxt_addr,
  output bank_t         nxt_bank,
  output logic          wr_ok,
  output logic [AW-1:0] acc_addr,
  output bank_t         acc_bank
);
  logic load;

  always_comb begin
    load     = !adsp_n || !adsc_n;
    wr_ok    = adsp_n;
    nxt_addr = acc_addr;
    nxt_bank = acc_bank;
    if (load) begin
      nxt_addr = addr;
      nxt_bank = pick_bank(en1_n, en2_n);
    end else if (!adv_n) begin
      nxt_addr = {acc_addr[AW-1:2], acc_addr[1:0] + 2'd1};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_addr <= '0;
      acc_bank <= '0;
    end else begin
      acc_addr <= nxt_addr;
      acc_bank <= nxt_bank;
    end
  end
endmodule

// File: rtl/write_decode.sv
module write_decode
  import sram_pkg::*;
(
  input  logic                        gw_n,
  input  logic                        bwe_n,
  input  logic [LANES-1:0]            bw_n,
  input  logic                        wr_ok,
  input  bank_t                       bank,
  output logic [BANKS-1:0][LANES-1:0] lane_we
);
  logic [LANES-1:0] mask;

  always_comb begin
    if (!gw_n)       mask = '1;
    else if (!bwe_n) mask = ~bw_n;
    else             mask = '0;
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign lane_we[b] = (wr_ok && bank[b]) ? mask : '0;
  end
endmodule

// File: rtl/bank_array.sv
module bank_array
  import sram_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [LANES-1:0]  we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we[l]) mem[waddr] <= wdata[l*LANE_W +: LANE_W];
    end

    assign rdata[l*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sram_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     addr,
  input  logic              adsc_n,
  input  logic              adsp_n,
  input  logic              adv_n,
  input  logic              en1_n,
  input  logic              en2_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic              oe_n,
  input  logic [WORD_W-1:0] dq_in,
  output logic [WORD_W-1:0] dq_out,
  output logic              dq_oe
);
  logic [AW-1:0]              nxt_addr;
  logic [AW-1:0]              acc_addr;
  bank_t                      nxt_bank;
  bank_t                      acc_bank;
  logic                       wr_ok;
  logic [BANKS-1:0][LANES-1:0] lane_we;
  logic [WORD_W-1:0]          rd_word [BANKS];
  logic                       wr_q;

  burst_addr_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .addr(addr),
    .adsc_n(adsc_n), .adsp_n(adsp_n), .adv_n(adv_n),
    .en1_n(en1_n), .en2_n(en2_n),
    .nxt_addr(nxt_addr), .nxt_bank(nxt_bank), .wr_ok(wr_ok),
    .acc_addr(acc_addr), .acc_bank(acc_bank)
  );

  write_decode u_dec (
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
    .wr_ok(wr_ok), .bank(nxt_bank), .lane_we(lane_we)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    bank_array #(.DEPTH(DEPTH)) u_arr (
      .clk(clk), .we(lane_we[b]), .waddr(nxt_addr), .wdata(dq_in),
      .raddr(acc_addr), .rdata(rd_word[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) wr_q <= 1'b0;
    else     wr_q <= |lane_we;
  end

  // flow-through: no register between array and pins
  assign dq_out = acc_bank[1] ? rd_word[1] : rd_word[0];
  assign dq_oe  = !oe_n && (|acc_bank) && !wr_q;
endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          oe_n,
  input logic          adsc_n,
  input logic          adsp_n,
  input logic          adv_n,
  input logic          gw_n,
  input logic          bwe_n,
  input logic          dq_oe,
  input logic [AW-1:0] acc_addr,
  input logic [1:0]    acc_bank,
  input logic          wr_q,
  input logic [15:0]   lane_we
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !dq_oe);

  // R7
  oe_gate_chk: assert property (@(posedge clk) disable iff (rst) oe_n |-> !dq_oe);

  // R6
  burst_step_chk: assert property (@(posedge clk) disable iff (rst)
    (adsc_n && adsp_n && !adv_n) |=>
      (acc_addr[1:0] == $past(acc_addr[1:0]) + 2'd1) &&
      (acc_addr[AW-1:2] == $past(acc_addr[AW-1:2])));

  // R12
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (adsc_n && adsp_n) |=> (acc_bank == $past(acc_bank)));

  // R8
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_bank == 2'b00) |-> !dq_oe);

  // R11
  write_turn_chk: assert property (@(posedge clk) disable iff (rst) wr_q |-> !dq_oe);

  // R10
  adsp_read_chk: assert property (@(posedge clk) disable iff (rst)
    !adsp_n |-> (lane_we == '0));

  // R5
  no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (gw_n && bwe_n) |-> (lane_we == '0));
endmodule

bind sync_burst_sram sync_burst_sram_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .oe_n(oe_n), .adsc_n(adsc_n), .adsp_n(adsp_n),
  .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n), .dq_oe(dq_oe),
  .acc_addr(acc_addr), .acc_bank(acc_bank), .wr_q(wr_q), .lane_we(lane_we)
);

// File: tb/sync_burst_sram_test.sv
module sync_burst_sram_test;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int W     = 72;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr;
  logic          adsc_n, adsp_n, adv_n, en1_n, en2_n, gw_n, bwe_n, oe_n;
  logic [7:0]    bw_n;
  logic [W-1:0]  dq_in;
  logic [W-1:0]  dq_out;
  logic          dq_oe;

  int nchk = 0;
  int nfail = 0;

  logic [W-1:0]  ref_mem [2][DEPTH];
  logic [AW-1:0] m_addr;
  int            m_bank;
  logic          m_wr;

  always #4 clk = ~clk;

  sync_burst_sram #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .addr(addr), .adsc_n(adsc_n), .adsp_n(adsp_n),
    .adv_n(adv_n), .en1_n(en1_n), .en2_n(en2_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .bw_n(bw_n), .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic logic [W-1:0] rnd_word();
    logic [95:0] t;
    t = {$urandom, $urandom, $urandom};
    return t[W-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference behaviour at a clock edge, from the requirements
  task automatic model_edge();
    bit load;
    bit wok;
    logic [AW-1:0] na;
    int nb;
    logic [7:0] mask;
    load = !adsp_n || !adsc_n;
    wok  = adsp_n;
    na = m_addr;
    nb = m_bank;
    if (load) begin
      na = addr;
      nb = !en1_n ? 0 : (!en2_n ? 1 : -1);
    end else if (!adv_n) begin
      na = {m_addr[AW-1:2], m_addr[1:0] + 2'd1};
    end
    mask = !gw_n ? 8'hFF : (!bwe_n ? ~bw_n : 8'h00);
    m_wr = 1'b0;
    if (wok && nb >= 0 && mask != 0) begin
      m_wr = 1'b1;
      for (int l = 0; l < 8; l++)
        if (mask[l]) ref_mem[nb][na][l*9 +: 9] = dq_in[l*9 +: 9];
    end
    m_addr = na;
    m_bank = nb;
  endtask

  task automatic step(input string req);
    bit exp_oe;
    @(posedge clk);
    if (rst) begin
      m_addr = '0;
      m_bank = -1;
      m_wr   = 1'b0;
    end else model_edge();
    @(negedge clk);
    exp_oe = !oe_n && (m_bank >= 0) && !m_wr;
    check(dq_oe == exp_oe, req, {71'd0, dq_oe}, {71'd0, exp_oe});
    if (exp_oe)
      check(dq_out == ref_mem[m_bank][m_addr], req, dq_out, ref_mem[m_bank][m_addr]);
  endtask

  task automatic idle();
    adsc_n = 1'b1; adsp_n = 1'b1; adv_n = 1'b1;
    gw_n = 1'b1; bwe_n = 1'b1; bw_n = 8'hFF;
  endtask

  task automatic load_c(input logic [AW-1:0] a, input logic e1, input logic e2);
    idle();
    adsc_n = 1'b0; addr = a; en1_n = e1; en2_n = e2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    nchk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    rst = 1'b1; oe_n = 1'b0; addr = '0; en1_n = 1'b1; en2_n = 1'b1;
    dq_in = '0;
    idle();
    @(negedge clk);
    step("R1");
    step("R1");
    rst = 1'b0;

    // R3: fill both banks with global write, lane controls set to inhibit
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < DEPTH; a++) begin
        load_c(a[AW-1:0], b == 1, b == 0);
        gw_n = 1'b0; bwe_n = 1'b1; bw_n = 8'hFF; dq_in = rnd_word();
        step("R3");
      end
    load_c(4'd3, 1'b0, 1'b1);
    step("R3");

    // R11: write then read same word next cycle
    load_c(4'd5, 1'b0, 1'b1); gw_n = 1'b0; dq_in = rnd_word();
    step("R11");
    load_c(4'd5, 1'b0, 1'b1);
    step("R11");

    // R4: lane mask write
    load_c(4'd5, 1'b0, 1'b1); bwe_n = 1'b0; bw_n = 8'b1010_1010; dq_in = rnd_word();
    step("R4");
    load_c(4'd5, 1'b0, 1'b1);
    step("R4");

    // R5: lane enables without mode gate
    load_c(4'd5, 1'b0, 1'b1); bwe_n = 1'b1; bw_n = 8'h00; dq_in = rnd_word();
    step("R5");
    load_c(4'd5, 1'b0, 1'b1);
    step("R5");

    // R2 / R6: burst from 6 wraps 6,7,4,5 then holds
    load_c(4'd6, 1'b0, 1'b1);
    step("R2");
    for (int k = 0; k < 3; k++) begin
      idle(); adv_n = 1'b0;
      step("R6");
    end
    idle();
    step("R6");

    // R7: asynchronous output enable
    oe_n = 1'b1; #1;
    check(dq_oe == 1'b0, "R7", {71'd0, dq_oe}, '0);
    oe_n = 1'b0; #1;
    check(dq_oe == 1'b1, "R7", {71'd0, dq_oe}, 72'd1);

    // R8: deselected write
    load_c(4'd2, 1'b1, 1'b1); gw_n = 1'b0; dq_in = rnd_word();
    step("R8");
    load_c(4'd2, 1'b0, 1'b1);
    step("R8");
    load_c(4'd2, 1'b1, 1'b0);
    step("R8");

    // R9: both enables low picks bank 0
    load_c(4'd9, 1'b0, 1'b0); gw_n = 1'b0; dq_in = rnd_word();
    step("R9");
    load_c(4'd9, 1'b1, 1'b0);
    step("R9");
    load_c(4'd9, 1'b0, 1'b1);
    step("R9");

    // R10: processor strobe load ignores write controls
    idle(); adsp_n = 1'b0; adsc_n = 1'b0; addr = 4'd9; en1_n = 1'b0; en2_n = 1'b1;
    gw_n = 1'b0; dq_in = rnd_word();
    step("R10");
    load_c(4'd9, 1'b0, 1'b1);
    step("R10");

    // R12: bank held through burst when enables change
    load_c(4'd12, 1'b1, 1'b0);
    step("R12");
    idle(); adv_n = 1'b0; en1_n = 1'b0; en2_n = 1'b1;
    step("R12");
    idle(); en1_n = 1'b1; en2_n = 1'b1;
    step("R12");

    // random mix, including writes coinciding with burst advance
    for (int i = 0; i < 4000; i++) begin
      int r;
      idle();
      r = $urandom_range(0, 9);
      if (r < 3) begin
        adsc_n = 1'b0; addr = $urandom_range(0, DEPTH - 1);
      end else if (r < 4) begin
        adsp_n = 1'b0; adsc_n = $urandom_range(0, 1); addr = $urandom_range(0, DEPTH - 1);
      end else if (r < 8) adv_n = 1'b0;
      en1_n = ($urandom_range(0, 3) == 0);
      en2_n = $urandom_range(0, 1);
      gw_n  = ($urandom_range(0, 4) != 0);
      bwe_n = $urandom_range(0, 1);
      bw_n  = $urandom;
      oe_n  = ($urandom_range(0, 7) == 0);
      dq_in = rnd_word();
      step("R6");
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule